// File: doc/BRIEF.md
# Clocked Bus Read Sequencer with Ready-Driven Wait States

This block is a bus master that performs one read at a time on a parallel processor-to-memory bus. It works in whole clock states. A request carrying an address starts the sequence. The block first puts the address on the bus for one clock. In the next clock it raises the read strobe. It then takes the data word on the first rising edge at which the memory's ready line is high. After that it drops the strobe and the address and reports the word with a one-clock completion pulse.

A slow memory stretches the access by holding ready low. It pulls ready low while it sees the read strobe and cannot yet supply data. For every rising edge that samples ready low, the sequencer adds one wait state, and it keeps the address and strobe exactly as they were. The cycle length therefore follows each memory's response time. A parameter sets the largest number of wait states allowed. If ready is still low once that many have passed, the access ends with an error pulse in place of completion. While a read is in progress, a busy output tells the requester that new requests are not being taken.

Top module: `rdseq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, the read strobe, the completion pulse and the error pulse are all 0, and the address bus reads 0.
- R2: A request seen at a rising edge while the block is idle starts an access. In the next cycle, busy is 1, the requested address is on the address bus and the read strobe is still 0 (address state).
- R3: In the cycle after the address state, the read strobe is 1 and the address bus is unchanged (read state).
- R4: If ready is 1 at the rising edge that ends the read state, the data bus is captured at that edge with no wait state. The completion pulse is then high in the third cycle after the accepting edge.
- R5: Each rising edge during the strobe that samples ready at 0 adds exactly one wait state. During a wait state the read strobe stays 1 and the address bus holds its value. A memory that needs N wait states gives completion N cycles later than the zero-wait case.
- R6: The data output carries the word present on the data bus at the edge where ready was sampled 1. The completion pulse lasts exactly one cycle.
- R7: In the cycle that shows completion or error, the read strobe is 0, busy is 0 and the address bus reads 0.
- R8: A request raised while busy is 1 is ignored. The address bus keeps the accepted address, and no further access follows once the current one ends.
- R9: With MAX_WAIT set to M, ready sampled 1 on the edge ending the M-th wait state still completes normally. If ready is still 0 there, the access ends: the error pulse is 1 for one cycle in the cycle that would have been the (M+1)-th wait state, and no completion pulse is given.
- R10: The completion pulse and the error pulse are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request to start a read; taken only while idle |
| req_addr | input | AW | Address for the requested read |
| busy | output | 1 | High from the address state until the access ends |
| bus_addr | output | AW | Address lines to memory; 0 when idle |
| bus_rd | output | 1 | Read strobe to memory |
| bus_rdy | input | 1 | Memory ready, sampled at each rising edge while the strobe is high |
| bus_data | input | DW | Data lines from memory |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Word captured by the last completed read |
| rsp_err | output | 1 | One-cycle pulse when the wait-state limit is exceeded |

## Verification
The checks on strobe timing take for granted that ready is a clean, synchronous level that matters only while the strobe is high. They also assume the memory does not change its data in the same cycle in which it raises ready. The bench meets both conditions with a small memory model. The model counts the edges that have seen the strobe high and holds ready low until a chosen latency has passed. Until then it drives the inverse of the correct word on the data lines, so any read taken too early returns a wrong value. Requests are driven half a clock away from the sampling edge. Each latency stays between zero and one past the wait-state limit, so both the normal ending and the error ending are reached.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_READ = 2'd2,
    ST_WAIT = 2'd3
  } rdseq_state_e;

endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         bus_rdy,
  input  logic         wait_exhausted,
  output rdseq_state_e state,
  output logic         accept,
  output logic         capture,
  output logic         abort
);

  rdseq_state_e state_q, state_d;

  // next-state process
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    abort   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR: state_d = ST_READ;
      ST_READ: begin
        if (bus_rdy) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (bus_rdy) begin
          capture = 1'b1;
          state_d = ST_IDLE;
        end else if (wait_exhausted) begin
          abort   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

endmodule

// File: rtl/rdseq_waitcnt.sv
module rdseq_waitcnt #(
  parameter int MAX_WAIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  output logic exhausted
);

  localparam int WCW = $clog2(MAX_WAIT + 1) + 1;

  logic [WCW-1:0] cnt_q, cnt_d;
  logic           cnt_en;

  assign cnt_en = start | step;

  always_comb begin
    if (start) cnt_d = WCW'(1);
    else       cnt_d = cnt_q + WCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign exhausted = (cnt_q == WCW'(MAX_WAIT));

endmodule

// File: rtl/rdseq_dpath.sv
module rdseq_dpath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          abort,
  input  logic          active,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] bus_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_done,
  output logic          rsp_err
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          done_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= bus_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= capture;
      err_q  <= abort;
    end
  end

  assign bus_addr = active ? addr_q : '0;
  assign rsp_data = data_q;
  assign rsp_done = done_q;
  assign rsp_err  = err_q;

endmodule

// File: rtl/rdseq_top.sv
module rdseq_top
  import rdseq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int MAX_WAIT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  input  logic          bus_rdy,
  input  logic [DW-1:0] bus_data,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err
);

  rdseq_state_e state;
  logic accept, capture, abort, wait_exhausted;
  logic wait_start, wait_step;

  rdseq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .bus_rdy        (bus_rdy),
    .wait_exhausted (wait_exhausted),
    .state          (state),
    .accept         (accept),
    .capture        (capture),
    .abort          (abort)
  );

  assign wait_start = (state == ST_READ) && !bus_rdy;
  assign wait_step  = (state == ST_WAIT) && !bus_rdy && !wait_exhausted;

  rdseq_waitcnt #(.MAX_WAIT(MAX_WAIT)) u_waitcnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (wait_start),
    .step      (wait_step),
    .exhausted (wait_exhausted)
  );

  assign busy   = (state != ST_IDLE);
  assign bus_rd = (state == ST_READ) || (state == ST_WAIT);

  rdseq_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .abort    (abort),
    .active   (busy),
    .req_addr (req_addr),
    .bus_data (bus_data),
    .bus_addr (bus_addr),
    .rsp_data (rsp_data),
    .rsp_done (rsp_done),
    .rsp_err  (rsp_err)
  );

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk #(
  parameter int AW       = 16,
  parameter int MAX_WAIT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          rsp_done,
  input logic          rsp_err
);

  localparam int RCW = $clog2(MAX_WAIT + 2) + 1;

  logic [RCW-1:0] rd_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_run <= '0;
    else if (bus_rd) rd_run <= rd_run + RCW'(1);
    else             rd_run <= '0;
  end

  AST_STROBE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |-> $past(busy)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && $past(bus_rd)) |-> (bus_addr == $past(bus_addr))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R6

  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_err) |-> (!bus_rd && !busy)); // R7

  AST_WAIT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (rd_run <= RCW'(MAX_WAIT))); // R9

  AST_ENDS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err)); // R10

endmodule

bind rdseq_top rdseq_chk #(.AW(AW), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .rsp_done (rsp_done),
  .rsp_err  (rsp_err)
);

// File: tb/rdseq_top_bench.sv
module rdseq_top_bench;

  localparam int AW       = 16;
  localparam int DW       = 8;
  localparam int MAX_WAIT = 4;
  localparam int NVEC     = 6;

  // each entry: {address, memory latency in wait states}
  localparam logic [19:0] VECS [0:NVEC-1] = '{
    {16'h1234, 4'd0}, {16'hABCD, 4'd1}, {16'h00FF, 4'd2},
    {16'h8001, 4'd3}, {16'h5A5A, 4'd4}, {16'hFFFF, 4'd5}
  };

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          busy;
  logic [AW-1:0] bus_addr;
  logic          bus_rd;
  logic          bus_rdy;
  logic [DW-1:0] bus_data;
  logic          rsp_done;
  logic [DW-1:0] rsp_data;
  logic          rsp_err;

  int n_checks = 0;
  int n_fails  = 0;
  logic [3:0] lat;
  logic [3:0] rd_age;

  rdseq_top #(.AW(AW), .DW(DW), .MAX_WAIT(MAX_WAIT)) u_rdseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .busy(busy), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdy(bus_rdy),
    .bus_data(bus_data), .rsp_done(rsp_done), .rsp_data(rsp_data),
    .rsp_err(rsp_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // memory model: ready low until lat edges have seen the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_age <= '0;
    else if (bus_rd) rd_age <= rd_age + 4'd1;
    else             rd_age <= '0;
  end
  assign bus_rdy  = !bus_rd || (rd_age >= lat);
  assign bus_data = bus_rdy ? mem_word(bus_addr) : ~mem_word(bus_addr);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_read(input logic [AW-1:0] a, input logic [3:0] l, input logic intrude);
    int n;
    logic ended;
    @(negedge clk);
    lat       = l;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    chk(busy && bus_addr == a && !bus_rd, "R2", {busy, bus_rd, bus_addr}, {2'b10, a});
    @(negedge clk);
    chk(bus_rd && bus_addr == a, "R3", {bus_rd, bus_addr}, {1'b1, a});
    n = 2;
    ended = 1'b0;
    for (int k = 0; k < 20 && !ended; k++) begin
      @(negedge clk);
      n++;
      if (rsp_done || rsp_err) begin
        ended     = 1'b1;
        req_valid = 1'b0;
      end else begin
        chk(bus_rd && bus_addr == a, "R5", {bus_rd, bus_addr}, {1'b1, a});
        if (intrude) req_valid = 1'b1;
      end
    end
    if (l <= MAX_WAIT) begin
      chk(rsp_done && !rsp_err && n == 3 + l, "R4/R5 completion cycle", n, 3 + l);
      chk(rsp_data == mem_word(a), "R6 data", rsp_data, mem_word(a));
    end else begin
      chk(rsp_err && !rsp_done && n == 3 + MAX_WAIT, "R9 abort cycle", n, 3 + MAX_WAIT);
      chk(!(rsp_done && rsp_err), "R10", {rsp_done, rsp_err}, 2'b01);
    end
    chk(!bus_rd && !busy && bus_addr == '0, "R7", {bus_rd, busy, bus_addr}, 0);
    @(negedge clk);
    chk(!rsp_done && !rsp_err, "R6 single pulse", {rsp_done, rsp_err}, 0);
    if (intrude) chk(!busy, "R8 no queued access", busy, 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    lat       = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_rd && !rsp_done && !rsp_err && bus_addr == '0, "R1 in reset",
        {busy, bus_rd, rsp_done, rsp_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bus_rd && !rsp_done && !rsp_err && bus_addr == '0, "R1 after reset",
        {busy, bus_rd, rsp_done, rsp_err}, 0);

    for (int i = 0; i < NVEC; i++) begin
      run_read(VECS[i][19:4], VECS[i][3:0], 1'b0);
    end

    // R8: requests raised during wait states are ignored
    run_read(16'h0F0F, 4'd2, 1'b1);
    // R9: exactly at the limit still completes, one beyond aborts
    run_read(16'h2468, 4'(MAX_WAIT), 1'b0);
    run_read(16'h1357, 4'(MAX_WAIT + 1), 1'b0);
    // R4: back-to-back zero-wait reads after an abort
    run_read(16'h7777, 4'd0, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule